// File: doc/BRIEF.md
# Logic Self-Test Shell with Pattern Generator and Signature Register

This block wraps a small combinational core between two identical multi-mode registers. The register on the input side feeds the core. The register on the output side captures what the core produces. A 2-bit mode input chooses how both registers behave during ordinary use:
- plain parallel capture;
- a serial scan chain;
- a free-running pseudo-random generator;
- a parallel-input signature compactor.

A one-cycle start pulse hands control to an internal sequencer and runs a self-test. Both registers are preset. The input register then produces pseudo-random patterns while the output register folds the core's responses into a signature, for a fixed number of cycles. The final signature is compared with a constant supplied at build time. The block then raises a one-cycle done strobe together with a pass or fail verdict, and the verdict holds until the next start.

The scan chain enters at the output side and leaves from the input side. A break in the chain therefore still lets the output register be loaded and observed. The core is a stand-in mapping. A build parameter can tie one of its output bits low so that the self-test can be shown to catch a fault.

Top module: `lbist_wrap`

## Requirements
- R1: After reset both registers hold zero, so data_out and scan_out are 0, and done, pass and fail are low.
- R2: With func_mode = 2'b10 (parallel), each clock the input register takes data_in and the output register takes core(input register). The core is y = rotl(x,3) XOR (x + 8'h5A), and data_out shows the output register.
- R3: With func_mode = 2'b00 (scan), scan_in enters output-register bit 0 and each register shifts toward its MSB. The output-register MSB enters input-register bit 0, and scan_out is the input-register MSB, giving a 16-cycle chain.
- R4: With func_mode = 2'b11 (generate), each register steps as q <= {q[6:0], q[7]^q[5]^q[4]^q[3]}, which is the polynomial x^8+x^6+x^5+x^4+1. Any nonzero state returns to itself after 255 steps.
- R5: With func_mode = 2'b01 (compress), each register takes its generate-mode next state XOR its parallel input. For the input register that input is data_in, and for the output register it is core(input register).
- R6: A start pulse presets the input register to SEED (8'h01) and the output register to 0 on that edge. Over the next 255 edges the input register generates and the output register compresses the core response, whatever func_mode and data_in are. data_out then shows the signature.
- R7: done is high for exactly one cycle, the cycle after the 256th edge following the start edge. The start edge clears done, pass and fail. pass and fail then hold until the next start.
- R8: With done, exactly one of pass and fail is high. pass is high when the signature equals the EXPECT parameter.
- R9: When the core is built with one output bit stuck at 0, the self-test ends with fail high and pass low.
- R10: A start pulse during a running self-test restarts it, and done appears only 256 edges after the latest start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_mode | input | 2 | Register mode outside self-test: 00 scan, 01 compress, 10 parallel, 11 generate |
| start | input | 1 | One-cycle pulse that starts or restarts the self-test |
| data_in | input | W | Parallel data into the input register |
| data_out | output | W | Contents of the output register |
| scan_in | input | 1 | Serial data into the chain at the output register |
| scan_out | output | 1 | Serial data out of the chain from the input register |
| done | output | 1 | One-cycle strobe at the end of a self-test |
| pass | output | 1 | Signature matched, held until next start |
| fail | output | 1 | Signature mismatched, held until next start |

## Verification
A wrong register state reaches data_out in the next cycle when the wrong state is in the output register. A wrong state in the input register shows on scan_out at once in scan mode. Otherwise it reaches data_out one cycle later through the core. During a self-test, one bad generated pattern or one bad compaction step leaves a wrong signature on data_out when the run ends. It also flips the verdict, so every such error becomes visible at the verdict 256 cycles after start. A sequencer that miscounts shows up as done arriving on the wrong cycle.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  typedef enum logic [1:0] {
    MD_SHIFT = 2'b00,
    MD_COMP  = 2'b01,
    MD_LOAD  = 2'b10,
    MD_GEN   = 2'b11
  } reg_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_RUN  = 2'b01,
    SQ_FIN  = 2'b10
  } seq_state_e;

endpackage

// File: rtl/lbist_modereg.sv
module lbist_modereg
  import lbist_pkg::*;
#(
  parameter int             W    = 8,
  parameter logic [W-1:0]   TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  reg_mode_e    mode,
  input  logic         preset,
  input  logic [W-1:0] preset_val,
  input  logic [W-1:0] pdata,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic         sout
);

  // feedback bit of the linear shift register
  function automatic logic fb_bit(input logic [W-1:0] v);
    return ^(v & TAPS);
  endfunction

  // shift toward the MSB, new bit at position 0
  function automatic logic [W-1:0] shl_in(input logic [W-1:0] v, input logic b);
    return {v[W-2:0], b};
  endfunction

  function automatic logic [W-1:0] gen_next(input logic [W-1:0] v);
    return shl_in(v, fb_bit(v));
  endfunction

  function automatic logic [W-1:0] comp_next(input logic [W-1:0] v, input logic [W-1:0] d);
    return gen_next(v) ^ d;
  endfunction

  logic [W-1:0] nxt;

  always_comb begin
    unique case (mode)
      MD_SHIFT: nxt = shl_in(q, sin);
      MD_COMP:  nxt = comp_next(q, pdata);
      MD_LOAD:  nxt = pdata;
      MD_GEN:   nxt = gen_next(q);
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (preset) q <= preset_val;
    else             q <= nxt;
  end

  assign sout = q[W-1];

endmodule

// File: rtl/lbist_stub_core.sv
module lbist_stub_core #(
  parameter int           W         = 8,
  parameter int           ROT       = 3,
  parameter logic [W-1:0] ADD       = 8'h5A,
  parameter int           FAULT_BIT = -1
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);

  function automatic logic [W-1:0] core_map(input logic [W-1:0] v);
    logic [W-1:0] rot;
    rot = (v << ROT) | (v >> (W - ROT));
    return rot ^ (v + ADD);
  endfunction

  logic [W-1:0] y_good;
  assign y_good = core_map(x);

  generate
    if (FAULT_BIT >= 0 && FAULT_BIT < W) begin : g_stuck
      always_comb begin
        y = y_good;
        y[FAULT_BIT] = 1'b0;
      end
    end else begin : g_clean
      assign y = y_good;
    end
  endgenerate

endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int           W       = 8,
  parameter int           RUN_LEN = 255,
  parameter logic [W-1:0] EXPECT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] sig,
  output logic         run_active,
  output logic         preset,
  output logic         done,
  output logic         pass,
  output logic         fail
);

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  function automatic logic sig_ok(input logic [W-1:0] s);
    return s == EXPECT;
  endfunction

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic          last_step;
  logic          sig_match;

  assign last_step  = (state == SQ_RUN) && (cnt == LAST);
  assign sig_match  = sig_ok(sig);
  assign run_active = (state == SQ_RUN);
  assign preset     = start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
      pass  <= 1'b0;
      fail  <= 1'b0;
    end else if (start) begin
      state <= SQ_RUN;
      cnt   <= '0;
      done  <= 1'b0;
      pass  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      unique case (state)
        SQ_RUN: begin
          if (last_step) state <= SQ_FIN;
          else           cnt   <= cnt + 1'b1;
        end
        SQ_FIN: begin
          done  <= 1'b1;
          pass  <= sig_match;
          fail  <= !sig_match;
          state <= SQ_IDLE;
        end
        default: begin
          done <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/lbist_wrap.sv
module lbist_wrap
  import lbist_pkg::*;
#(
  parameter int           W         = 8,
  parameter logic [W-1:0] TAPS      = 8'hB8,
  parameter logic [W-1:0] SEED      = 8'h01,
  parameter int           RUN_LEN   = 255,
  parameter logic [W-1:0] EXPECT    = 8'h00,
  parameter int           CORE_ROT  = 3,
  parameter logic [W-1:0] CORE_ADD  = 8'h5A,
  parameter int           FAULT_BIT = -1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   func_mode,
  input  logic         start,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] data_out,
  input  logic         scan_in,
  output logic         scan_out,
  output logic         done,
  output logic         pass,
  output logic         fail
);

  logic         run_active;
  logic         preset;
  logic [W-1:0] in_q;
  logic [W-1:0] out_q;
  logic [W-1:0] core_y;
  logic         out_sout;
  reg_mode_e    in_mode;
  reg_mode_e    out_mode;

  assign in_mode  = run_active ? MD_GEN  : reg_mode_e'(func_mode);
  assign out_mode = run_active ? MD_COMP : reg_mode_e'(func_mode);

  lbist_modereg #(.W(W), .TAPS(TAPS)) u_in_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (in_mode),
    .preset     (preset),
    .preset_val (SEED),
    .pdata      (data_in),
    .sin        (out_sout),
    .q          (in_q),
    .sout       (scan_out)
  );

  lbist_stub_core #(.W(W), .ROT(CORE_ROT), .ADD(CORE_ADD), .FAULT_BIT(FAULT_BIT)) u_core (
    .x (in_q),
    .y (core_y)
  );

  lbist_modereg #(.W(W), .TAPS(TAPS)) u_out_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (out_mode),
    .preset     (preset),
    .preset_val ('0),
    .pdata      (core_y),
    .sin        (scan_in),
    .q          (out_q),
    .sout       (out_sout)
  );

  lbist_seq #(.W(W), .RUN_LEN(RUN_LEN), .EXPECT(EXPECT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .sig        (out_q),
    .run_active (run_active),
    .preset     (preset),
    .done       (done),
    .pass       (pass),
    .fail       (fail)
  );

  assign data_out = out_q;

endmodule

// File: rtl/lbist_wrap_chk.sv
module lbist_wrap_chk #(
  parameter int           W       = 8,
  parameter int           RUN_LEN = 255,
  parameter logic [W-1:0] SEED    = 8'h01
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   func_mode,
  input logic         run_active,
  input logic [W-1:0] in_q,
  input logic [W-1:0] out_q,
  input logic         scan_out,
  input logic         done,
  input logic         pass,
  input logic         fail
);

  localparam int SW = $clog2(RUN_LEN + 3);
  localparam logic [SW-1:0] SMAX = {SW{1'b1}};

  logic [SW-1:0] since;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0;
      armed <= 1'b0;
    end else if (start) begin
      since <= '0;
      armed <= 1'b1;
    end else if (armed && since != SMAX) begin
      since <= since + 1'b1;
    end
  end

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (armed && since == SW'(RUN_LEN + 1)));

  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !pass && !fail));

  p_verdict_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(pass) || done));

  p_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  p_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (in_q == SEED && out_q == '0));

  p_scan_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !run_active && func_mode == 2'b00) |=> (scan_out == $past(in_q[W-2])));

endmodule

bind lbist_wrap lbist_wrap_chk #(.W(W), .RUN_LEN(RUN_LEN), .SEED(SEED)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .func_mode  (func_mode),
  .run_active (run_active),
  .in_q       (in_q),
  .out_q      (out_q),
  .scan_out   (scan_out),
  .done       (done),
  .pass       (pass),
  .fail       (fail)
);

// File: tb/lbist_wrap_bench.sv
`timescale 1ns/1ps
module lbist_wrap_bench;

  function automatic logic [7:0] m_lfsr(input logic [7:0] v);
    return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
  endfunction

  function automatic logic [7:0] m_core(input logic [7:0] x);
    logic [7:0] r;
    r = {x[4:0], x[7:5]};
    return r ^ (x + 8'h5A);
  endfunction

  function automatic logic [7:0] bench_sig();
    logic [7:0] g;
    logic [7:0] s;
    g = 8'h01;
    s = 8'h00;
    for (int i = 0; i < 255; i++) begin
      s = m_lfsr(s) ^ m_core(g);
      g = m_lfsr(g);
    end
    return s;
  endfunction

  localparam logic [7:0] EXP = bench_sig();

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] func_mode = 2'b10;
  logic       start = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic       scan_in = 1'b0;
  logic [7:0] data_out;
  logic       scan_out, done, pass, fail;
  logic [7:0] f_data_out;
  logic       f_scan_out, f_done, f_pass, f_fail;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_in = 8'h00;
  logic [7:0] m_out = 8'h00;

  always #10 clk = ~clk;

  lbist_wrap #(.EXPECT(EXP)) u_lbist_wrap (
    .clk(clk), .rst_n(rst_n), .func_mode(func_mode), .start(start),
    .data_in(data_in), .data_out(data_out), .scan_in(scan_in), .scan_out(scan_out),
    .done(done), .pass(pass), .fail(fail)
  );

  lbist_wrap #(.EXPECT(EXP), .FAULT_BIT(2)) u_lbist_wrap_flt (
    .clk(clk), .rst_n(rst_n), .func_mode(func_mode), .start(start),
    .data_in(data_in), .data_out(f_data_out), .scan_in(scan_in), .scan_out(f_scan_out),
    .done(f_done), .pass(f_pass), .fail(f_fail)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one functional-mode clock, model updated, outputs checked at the negedge
  task automatic fstep(input string tag, input logic [1:0] md, input logic [7:0] din,
                       input logic sbit);
    logic [7:0] ni, no;
    func_mode = md; data_in = din; scan_in = sbit;
    case (md)
      2'b00: begin ni = {m_in[6:0], m_out[7]}; no = {m_out[6:0], sbit}; end
      2'b01: begin ni = m_lfsr(m_in) ^ din;    no = m_lfsr(m_out) ^ m_core(m_in); end
      2'b10: begin ni = din;                   no = m_core(m_in); end
      default: begin ni = m_lfsr(m_in);        no = m_lfsr(m_out); end
    endcase
    @(negedge clk);
    m_in = ni; m_out = no;
    chk({tag, " data_out"}, data_out, m_out);
    chk({tag, " scan_out"}, {7'd0, scan_out}, {7'd0, m_in[7]});
  endtask

  task automatic t_reset();
    chk("R1 data_out", data_out, 8'h00);
    chk("R1 scan_out", {7'd0, scan_out}, 8'h00);
    chk("R1 done", {7'd0, done}, 8'h00);
    chk("R1 pass", {7'd0, pass}, 8'h00);
    chk("R1 fail", {7'd0, fail}, 8'h00);
  endtask

  task automatic t_load();
    fstep("R2 load", 2'b10, 8'h3C, 1'b0);
    fstep("R2 load", 2'b10, 8'h3C, 1'b0);
    chk("R2 core(3C)", data_out, m_core(8'h3C));
    fstep("R2 load", 2'b10, 8'hFF, 1'b0);
    fstep("R2 load", 2'b10, 8'h00, 1'b0);
    fstep("R2 load", 2'b10, 8'h81, 1'b0);
    fstep("R2 load", 2'b10, 8'h81, 1'b0);
    chk("R2 core(81)", data_out, m_core(8'h81));
  endtask

  task automatic t_shift();
    logic [15:0] pat = 16'b1100_1010_0111_0001;
    for (int i = 0; i < 16; i++) fstep("R3 shift", 2'b00, 8'hAA, pat[15-i]);
    chk("R3 first bit at scan_out", {7'd0, scan_out}, {7'd0, pat[15]});
    chk("R3 last byte in output reg", data_out, pat[7:0]);
  endtask

  task automatic t_gen();
    logic [7:0] start_val = 8'hA5;
    for (int i = 0; i < 8; i++) fstep("R4 preload", 2'b00, 8'h00, start_val[7-i]);
    chk("R4 preload value", data_out, start_val);
    for (int i = 0; i < 255; i++) fstep("R4 gen", 2'b11, 8'h55, 1'b1);
    chk("R4 period 255", data_out, start_val);
  endtask

  task automatic t_comp();
    for (int i = 0; i < 12; i++) fstep("R5 comp", 2'b01, 8'(i * 37 + 5), 1'b0);
    fstep("R5 comp zero data", 2'b01, 8'h00, 1'b0);
  endtask

  task automatic t_selftest(input int abort_after);
    int early_done = 0;
    if (abort_after > 0) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < abort_after; i++) begin
        @(negedge clk);
        if (done) early_done++;
      end
    end
    func_mode = 2'b10; data_in = 8'h3C;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6 preset output reg", data_out, 8'h00);
    chk("R7 start clears pass", {7'd0, pass}, 8'h00);
    chk("R7 start clears fail", {7'd0, fail}, 8'h00);
    for (int k = 1; k <= 255; k++) begin
      data_in = 8'(k * 13);
      func_mode = 2'(k);
      @(negedge clk);
      if (done) early_done++;
    end
    chk("R10 no early done", 8'(early_done), 8'h00);
    chk("R6 signature", data_out, EXP);
    @(negedge clk);
    chk("R7 done at 256", {7'd0, done}, 8'h01);
    chk("R8 pass", {7'd0, pass}, 8'h01);
    chk("R8 fail low", {7'd0, fail}, 8'h00);
    chk("R9 fault fail", {7'd0, f_fail}, 8'h01);
    chk("R9 fault pass low", {7'd0, f_pass}, 8'h00);
    @(negedge clk);
    chk("R7 done one cycle", {7'd0, done}, 8'h00);
    repeat (5) @(negedge clk);
    chk("R7 pass held", {7'd0, pass}, 8'h01);
    chk("R7 fault fail held", {7'd0, f_fail}, 8'h01);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_shift();
    t_gen();
    t_comp();
    t_selftest(0);
    t_selftest(100);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule